// File: doc/BRIEF.md
# Pipelined Restoring Array Divider

This block divides one unsigned integer by another and returns both quotient and remainder. It is a chain of identical restoring stages, one per quotient bit. Each stage shifts the running partial remainder left by one place, brings in the next dividend bit (most significant first), compares the result with the divisor, subtracts when it can, and records the outcome as one quotient bit.

A latency parameter sets the number of clock cycles of register delay through the chain. A latency of zero gives a purely combinational divider. A placement parameter picks the stage boundaries that carry those registers. A valid strobe travels through the same registers as the data, so each result appears with its own valid flag. The unit takes a new operand pair on every cycle.

Top module: `pipe_div`

## Requirements
- R1: For a non-zero divisor, a result on the outputs equals floor(dividend / divisor) on `quotient` and dividend mod divisor on `remainder`.
- R2: `out_valid` is high in exactly the cycle that comes LATENCY clock edges after the cycle in which `in_valid` was high. That cycle's quotient and remainder belong to those operands. Both outputs have the same latency.
- R3: With LATENCY = 0 the data path has no registers. `out_valid`, `quotient` and `remainder` follow the inputs in the same cycle.
- R4: A zero divisor gives a quotient of all ones and a remainder equal to the dividend, with no other indication.
- R5: Operand pairs may be presented on consecutive cycles with no gap, and every pair yields its own correct result.
- R6: Stage 0 consumes the dividend MSB, and stage k feeds boundary k. Boundary k carries a register when ((k - (W-1-PLACE)) mod W) < LATENCY. PLACE defaults to W/2, so PLACE = W-1 starts at the first stage, PLACE = 0 starts at the last stage, and the registers wrap around the chain when needed. Placement does not change the results or the latency.
- R7: LATENCY may be any value from 0 to W inclusive. A larger value, or a PLACE outside 0..W-1, stops elaboration.
- R8: While `rst_n` is low, `out_valid` of a registered divider stays low, whatever `in_valid` does.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Operand pair present this cycle |
| dividend | input | W | Unsigned dividend |
| divisor | input | W | Unsigned divisor |
| out_valid | output | 1 | Result present this cycle |
| quotient | output | W | Unsigned quotient |
| remainder | output | W | Unsigned remainder |

## Verification
Every pair of 4-bit operands is divided by four builds at once: combinational, a two-cycle middle placement, the full-depth LATENCY = W, and a three-register placement that wraps past the chain end. A misplaced or miscounted register shows up as a result with its valid flag a cycle early or late, or as data that no longer lines up with its flag. The zero-divisor rows catch a stage that treats zero as larger than the partial remainder, which would give a zero quotient. Gaps in the input stream and a held valid during reset catch flag leakage and the reuse of stale data.

// File: rtl/div_pkg.sv
`timescale 1ns/1ps
package div_pkg;
  // True when the boundary after stage k holds a register, given the stage
  // where insertion begins and the number of registers to place.
  function automatic bit boundary_reg(int k, int w, int lat, int start);
    int d;
    d = (k - start + w) % w;
    return (d < lat);
  endfunction
endpackage

// File: rtl/div_stage.sv
`timescale 1ns/1ps
module div_stage #(
  parameter int W = 8
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] dq_i,
  input  logic [W-1:0] den_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] dq_o
);
  logic [W:0]   trial;
  logic         fits;
  logic [W-1:0] rem_sub;

  always_comb begin
    trial   = {rem_i, dq_i[W-1]};
    fits    = (trial >= {1'b0, den_i});
    rem_sub = trial[W-1:0] - den_i;
    rem_o   = fits ? rem_sub : trial[W-1:0];
    dq_o    = {dq_i[W-2:0], fits};
  end

  // R1: a reduced partial remainder stays below the divisor.
  always_comb begin
    if (den_i != '0 && rem_i < den_i) begin
      a_r1_rem_below_den: assert (rem_o < den_i);
    end
  end

  // R4: a zero divisor always sets the quotient bit.
  always_comb begin
    if (den_i == '0) begin
      a_r4_zero_den_sets_bit: assert (dq_o[0] == 1'b1);
    end
  end
endmodule

// File: rtl/div_bound_reg.sv
`timescale 1ns/1ps
module div_bound_reg #(
  parameter int W  = 8,
  parameter bit EN = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         vld_d,
  input  logic [W-1:0] rem_d,
  input  logic [W-1:0] dq_d,
  input  logic [W-1:0] den_d,
  output logic         vld_q,
  output logic [W-1:0] rem_q,
  output logic [W-1:0] dq_q,
  output logic [W-1:0] den_q
);
  generate
    if (EN) begin : g_reg
      logic [W-1:0] rem_nx, dq_nx, den_nx;

      always_comb begin
        rem_nx = vld_d ? rem_d : rem_q;
        dq_nx  = vld_d ? dq_d  : dq_q;
        den_nx = vld_d ? den_d : den_q;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) vld_q <= 1'b0;
        else        vld_q <= vld_d;
      end

      always_ff @(posedge clk) begin
        rem_q <= rem_nx;
        dq_q  <= dq_nx;
        den_q <= den_nx;
      end

      // R2: an empty slot never turns into a valid one at the next boundary.
      a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !vld_d |=> !vld_q);
    end else begin : g_wire
      logic unused_clk_rst;
      assign unused_clk_rst = clk ^ rst_n;
      assign vld_q = vld_d;
      assign rem_q = rem_d;
      assign dq_q  = dq_d;
      assign den_q = den_d;
    end
  endgenerate
endmodule

// File: rtl/pipe_div.sv
`timescale 1ns/1ps
module pipe_div #(
  parameter int W       = 8,
  parameter int LATENCY = 0,
  parameter int PLACE   = W / 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         out_valid,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder
);
  localparam int START = W - 1 - PLACE;

  // R7: reject illegal settings at elaboration.
  generate
    if (LATENCY < 0 || LATENCY > W) begin : g_bad_latency
      $error("pipe_div: LATENCY must lie in 0..W");
    end
    if (PLACE < 0 || PLACE > W - 1) begin : g_bad_place
      $error("pipe_div: PLACE must lie in 0..W-1");
    end
    if (W < 2) begin : g_bad_width
      $error("pipe_div: W must be at least 2");
    end
  endgenerate

  logic [W-1:0] rem_s [0:W];
  logic [W-1:0] dq_s  [0:W];
  logic [W-1:0] den_s [0:W];
  logic         vld_s [0:W];
  logic [W-1:0] rem_c [0:W-1];
  logic [W-1:0] dq_c  [0:W-1];

  assign rem_s[0] = '0;
  assign dq_s[0]  = dividend;
  assign den_s[0] = divisor;
  assign vld_s[0] = in_valid;

  generate
    for (genvar k = 0; k < W; k++) begin : g_chain
      localparam bit HAS_REG = div_pkg::boundary_reg(k, W, LATENCY, START);

      div_stage #(.W(W)) u_stage (
        .rem_i (rem_s[k]),
        .dq_i  (dq_s[k]),
        .den_i (den_s[k]),
        .rem_o (rem_c[k]),
        .dq_o  (dq_c[k])
      );

      div_bound_reg #(.W(W), .EN(HAS_REG)) u_bound (
        .clk   (clk),
        .rst_n (rst_n),
        .vld_d (vld_s[k]),
        .rem_d (rem_c[k]),
        .dq_d  (dq_c[k]),
        .den_d (den_s[k]),
        .vld_q (vld_s[k+1]),
        .rem_q (rem_s[k+1]),
        .dq_q  (dq_s[k+1]),
        .den_q (den_s[k+1])
      );
    end
  endgenerate

  logic [W-1:0] unused_den_tail;
  assign unused_den_tail = den_s[W];

  assign out_valid = vld_s[W];
  assign quotient  = dq_s[W];
  assign remainder = rem_s[W];

  generate
    if (LATENCY == 0) begin : g_comb_chk
      // R3: with no registers the valid flag passes straight through.
      always_comb begin
        a_r3_comb_valid: assert (out_valid === in_valid);
      end
    end else begin : g_seq_chk
      // R8: a reset just released leaves no result flagged.
      a_r8_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !out_valid);
    end
  endgenerate
endmodule

// File: tb/test_pipe_div.sv
`timescale 1ns/1ps
module test_pipe_div;
  localparam int W  = 4;
  localparam int NC = 320;

  logic clk = 1'b0;
  logic rst_n;
  logic in_valid;
  logic [W-1:0] a_in, b_in;

  always #10 clk = ~clk;

  logic         ov0, ov1, ov2, ov3;
  logic [W-1:0] q0, q1, q2, q3, r0, r1, r2, r3;

  pipe_div #(.W(W), .LATENCY(0)) i_pipe_div_comb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dividend(a_in), .divisor(b_in),
    .out_valid(ov0), .quotient(q0), .remainder(r0));
  pipe_div #(.W(W), .LATENCY(2)) i_pipe_div (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dividend(a_in), .divisor(b_in),
    .out_valid(ov1), .quotient(q1), .remainder(r1));
  pipe_div #(.W(W), .LATENCY(W), .PLACE(W-1)) i_pipe_div_full (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dividend(a_in), .divisor(b_in),
    .out_valid(ov2), .quotient(q2), .remainder(r2));
  pipe_div #(.W(W), .LATENCY(3), .PLACE(0)) i_pipe_div_wrap (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .dividend(a_in), .divisor(b_in),
    .out_valid(ov3), .quotient(q3), .remainder(r3));

  int checks = 0;
  int fails  = 0;
  logic         hv [0:NC-1];
  logic [W-1:0] ha [0:NC-1];
  logic [W-1:0] hb [0:NC-1];

  task automatic check_one(input string tag, input int lat, input int n,
                           input logic ov, input logic [W-1:0] q, input logic [W-1:0] r);
    int idx;
    logic ev;
    int ea, eb, eq, er;
    idx = n - lat;
    ev  = (idx >= 0) ? hv[idx] : 1'b0;
    checks++;
    if (ov !== ev) begin
      fails++;
      $display("FAIL %s R2/R5 valid n=%0d actual=%b expected=%b", tag, n, ov, ev);
    end
    if (ev) begin
      ea = int'(ha[idx]);
      eb = int'(hb[idx]);
      if (eb == 0) begin eq = (1 << W) - 1; er = ea; end
      else begin eq = ea / eb; er = ea % eb; end
      checks++;
      if (int'(q) != eq || int'(r) != er) begin
        fails++;
        $display("FAIL %s %s a=%0d b=%0d actual q=%0d r=%0d expected q=%0d r=%0d",
                 tag, (eb == 0) ? "R4" : "R1", ea, eb, q, r, eq, er);
      end
    end
  endtask

  initial begin
    #(200000 * 20);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int p;
    rst_n    = 1'b0;
    in_valid = 1'b1;
    a_in     = 4'd9;
    b_in     = 4'd2;
    // R8: held valid during reset never reaches a registered output.
    repeat (3) begin
      @(negedge clk);
      #1;
      checks++;
      if (ov1 !== 1'b0 || ov2 !== 1'b0 || ov3 !== 1'b0) begin
        fails++;
        $display("FAIL R8 reset valid actual=%b%b%b expected=000", ov1, ov2, ov3);
      end
    end
    p = 0;
    for (int n = 0; n < NC; n++) begin
      @(negedge clk);
      rst_n = 1'b1;
      // R5: mostly back-to-back pairs with periodic gaps.
      if (p < 256 && (n % 7) != 3) begin
        hv[n] = 1'b1;
        ha[n] = 4'(p >> 4);
        hb[n] = 4'(p);
        p++;
      end else begin
        hv[n] = 1'b0;
        ha[n] = 4'(n * 5);
        hb[n] = 4'(n * 3);
      end
      in_valid = hv[n];
      a_in     = ha[n];
      b_in     = hb[n];
      #1;
      check_one("R3 comb",      0, n, ov0, q0, r0);
      check_one("R2 mid",       2, n, ov1, q1, r1);
      check_one("R7 full",      W, n, ov2, q2, r2);
      check_one("R6 wrap",      3, n, ov3, q3, r3);
    end
    checks++;
    if (p != 256) begin
      fails++;
      $display("FAIL R1 sweep coverage actual=%0d expected=256", p);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule